// File: doc/BRIEF.md
# Two-Phase Strobed Shift Register

This block is a serial shift register of `STAGES` stages, each `WIDTH` bits wide. Every stage holds two storage elements: an entry element and an exit element. Two separate strobes move data through the chain, and both are sampled as clock enables on one clock.

The load strobe fills every entry element. Stage 0 takes the serial input. Each later stage takes the exit element of the stage in front of it. The transfer strobe then copies each entry element into the exit element of the same stage. A word therefore moves forward by one stage for each load-then-transfer pair.

The serial output is the exit element of the last stage. A parallel output shows the exit elements of all stages. The two strobes must never be active together. If they are, the register keeps its contents and raises a clash flag.

Top module: `tpsr_top`

## Requirements
- R1: While `rst_ni` is low, every element clears to 0, so `par_o`, `ser_o` and `clash_o` all read 0.
- R2: A cycle with only `load_i` high loads stage 0's entry element from `ser_i` and loads each stage k>0's entry element from stage k-1's exit element. It leaves every exit element, and therefore `par_o`, unchanged.
- R3: A cycle with only `xfer_i` high copies each stage's entry element into that stage's exit element. The result is visible on `par_o` after that clock edge.
- R4: Words leave `ser_o` in the order they entered. A word presented with the first of `STAGES` load/transfer pairs appears on `ser_o` after the last of those pairs, and not earlier.
- R5: `par_o` packs stage k's exit element into bits [k*WIDTH +: WIDTH], with stage 0 in the least significant position. After two load/transfer pairs, stage 0 holds the second word and stage 1 holds the first word.
- R6: A cycle with `load_i` and `xfer_i` both high changes no element, and `clash_o` is 1 after that edge. `clash_o` returns to 0 after the next edge at which the strobes do not clash.
- R7: A cycle with neither strobe high changes no element.
- R8: A second transfer strobe with no load in between leaves `par_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load strobe, fills the entry elements |
| xfer_i | input | 1 | Transfer strobe, copies entry elements to exit elements |
| ser_i | input | WIDTH | Serial input word |
| ser_o | output | WIDTH | Exit element of the last stage |
| par_o | output | STAGES*WIDTH | Exit elements of all stages, stage 0 in the LSBs |
| clash_o | output | 1 | High for the cycle after both strobes were active together |

## Verification
The bench builds the block with its defaults, `STAGES`=4 and `WIDTH`=8. Four stages make the full-length traversal short enough to test the complete latency directly, both at the step before the word arrives and at the step it arrives. Byte-wide words let every test word carry a distinct value, so a word that lands in the wrong stage or in the wrong order shows up on `par_o`. Clash cycles are placed between a load and its transfer, so a register that wrongly updates on a clash is caught.

// File: rtl/tpsr_pkg.sv
package tpsr_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_XFER  = 2'd2,
    OP_CLASH = 2'd3
  } op_e;

  function automatic op_e decode_op(input logic load, input logic xfer);
    return op_e'({xfer, load});
  endfunction
endpackage

// File: rtl/tpsr_strobe_ctrl.sv
module tpsr_strobe_ctrl
  import tpsr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic xfer_i,
  output logic write_en_o,
  output logic move_en_o,
  output logic clash_o
);
  op_e op;
  logic clash_q;

  always_comb begin
    op         = decode_op(load_i, xfer_i);
    write_en_o = (op == OP_LOAD);
    move_en_o  = (op == OP_XFER);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clash_q <= 1'b0;
    else         clash_q <= (op == OP_CLASH);
  end

  assign clash_o = clash_q;

  p_enables_exclusive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(write_en_o && move_en_o));
  p_clash_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && xfer_i) |=> clash_o);
  p_clash_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && xfer_i) |=> !clash_o);
endmodule

// File: rtl/tpsr_stage.sv
module tpsr_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             write_en_i,
  input  logic             move_en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] second_o
);
  logic [WIDTH-1:0] first_q, second_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q  <= '0;
      second_q <= '0;
    end else begin
      if (write_en_i) first_q  <= d_i;
      if (move_en_i)  second_q <= first_q;
    end
  end

  assign second_o = second_q;

  p_move_copies_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    move_en_i |=> (second_o == $past(first_q)));
  p_load_keeps_exit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_en_i |=> $stable(second_o));
  p_load_takes_input_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_en_i |=> (first_q == $past(d_i)));
endmodule

// File: rtl/tpsr_top.sv
module tpsr_top #(
  parameter int STAGES = 4,
  parameter int WIDTH  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic                    xfer_i,
  input  logic [WIDTH-1:0]        ser_i,
  output logic [WIDTH-1:0]        ser_o,
  output logic [STAGES*WIDTH-1:0] par_o,
  output logic                    clash_o
);
  localparam int LAST = STAGES - 1;

  logic write_en, move_en;
  logic [WIDTH-1:0] exit_w [STAGES];

  tpsr_strobe_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .xfer_i     (xfer_i),
    .write_en_o (write_en),
    .move_en_o  (move_en),
    .clash_o    (clash_o)
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [WIDTH-1:0] feed;
    if (k == 0) begin : g_head
      assign feed = ser_i;
    end else begin : g_body
      assign feed = exit_w[k-1];
    end

    tpsr_stage #(.WIDTH(WIDTH)) u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .write_en_i (write_en),
      .move_en_i  (move_en),
      .d_i        (feed),
      .second_o   (exit_w[k])
    );

    assign par_o[k*WIDTH +: WIDTH] = exit_w[k];
  end

  assign ser_o = exit_w[LAST];

  p_clash_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clash_o |-> (par_o == $past(par_o)));
  p_idle_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !xfer_i) |=> $stable(par_o));
endmodule

// File: tb/tpsr_top_test.sv
module tpsr_top_test;
  localparam int STAGES = 4;
  localparam int WIDTH  = 8;
  localparam int PW     = STAGES * WIDTH;
  localparam int NVEC   = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic load_i = 1'b0, xfer_i = 1'b0;
  logic [WIDTH-1:0] ser_i = '0;
  logic [WIDTH-1:0] ser_o;
  logic [PW-1:0] par_o;
  logic clash_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [WIDTH-1:0] ent_m [STAGES];
  logic [WIDTH-1:0] ext_m [STAGES];
  logic clash_m;

  // {load, xfer, data}
  localparam logic [WIDTH+1:0] VEC [NVEC] = '{
    {2'b10, 8'h11}, {2'b01, 8'h00}, {2'b10, 8'h22}, {2'b00, 8'h00},
    {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b10, 8'h33}, {2'b11, 8'hEE},
    {2'b11, 8'hDD}, {2'b01, 8'h00}, {2'b10, 8'h44}, {2'b01, 8'h00},
    {2'b10, 8'h55}, {2'b10, 8'h66}, {2'b01, 8'h00}, {2'b00, 8'h77},
    {2'b11, 8'h88}, {2'b00, 8'h00}, {2'b10, 8'h99}, {2'b01, 8'h00}
  };

  always #10 clk = ~clk;

  tpsr_top #(.STAGES(STAGES), .WIDTH(WIDTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .xfer_i(xfer_i),
    .ser_i(ser_i), .ser_o(ser_o), .par_o(par_o), .clash_o(clash_o)
  );

  task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] pack_m();
    logic [PW-1:0] p;
    for (int k = 0; k < STAGES; k++) p[k*WIDTH +: WIDTH] = ext_m[k];
    return p;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < STAGES; k++) begin
      ent_m[k] = '0;
      ext_m[k] = '0;
    end
    clash_m = 1'b0;
  endtask

  // called at a negedge; returns at the next negedge with the model updated
  task automatic step(input logic l, input logic x, input logic [WIDTH-1:0] d);
    load_i = l; xfer_i = x; ser_i = d;
    @(negedge clk);
    load_i = 1'b0; xfer_i = 1'b0;
    if (l && !x) begin
      for (int k = STAGES - 1; k > 0; k--) ent_m[k] = ext_m[k-1];
      ent_m[0] = d;
    end else if (x && !l) begin
      for (int k = 0; k < STAGES; k++) ext_m[k] = ent_m[k];
    end
    clash_m = l && x;
  endtask

  task automatic check_all(input string tag);
    check({tag, " par_o"}, par_o, pack_m());
    check({tag, " ser_o"}, {{(PW-WIDTH){1'b0}}, ser_o}, {{(PW-WIDTH){1'b0}}, ext_m[STAGES-1]});
    check({tag, " clash_o"}, {{(PW-1){1'b0}}, clash_o}, {{(PW-1){1'b0}}, clash_m});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    @(negedge clk);
    // R1: outputs are clear while reset is held
    check_all("R1 in reset");
    rst_ni = 1'b1;

    // table walk covering R2 R3 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      logic l, x;
      l = VEC[i][WIDTH+1];
      x = VEC[i][WIDTH];
      step(l, x, VEC[i][WIDTH-1:0]);
      if (l && x)       check_all("R6 clash");
      else if (l)       check_all("R2 load");
      else if (x)       check_all("R3 xfer");
      else              check_all("R7 idle");
    end

    // R8: a repeated transfer with no load changes nothing
    step(1'b1, 1'b0, 8'hA5);
    step(1'b0, 1'b1, 8'h00);
    begin
      logic [PW-1:0] snap;
      snap = par_o;
      step(1'b0, 1'b1, 8'h00);
      check("R8 second xfer", par_o, snap);
    end

    // R1: asynchronous-style reset mid-run clears all state
    do_reset();
    check_all("R1 after reset");

    // R5: stage order after two pairs
    step(1'b1, 1'b0, 8'hC1); step(1'b0, 1'b1, 8'h00);
    step(1'b1, 1'b0, 8'hC2); step(1'b0, 1'b1, 8'h00);
    check("R5 stage0", {{(PW-WIDTH){1'b0}}, par_o[0 +: WIDTH]}, {{(PW-WIDTH){1'b0}}, 8'hC2});
    check("R5 stage1", {{(PW-WIDTH){1'b0}}, par_o[WIDTH +: WIDTH]}, {{(PW-WIDTH){1'b0}}, 8'hC1});

    // R4: latency of STAGES pairs and order preserved
    do_reset();
    for (int p = 0; p < STAGES + 2; p++) begin
      step(1'b1, 1'b0, 8'hB0 + WIDTH'(p));
      step(1'b0, 1'b1, 8'h00);
      if (p == STAGES - 2)
        check("R4 not yet", {{(PW-WIDTH){1'b0}}, ser_o}, '0);
      if (p >= STAGES - 1)
        check("R4 order", {{(PW-WIDTH){1'b0}}, ser_o},
              {{(PW-WIDTH){1'b0}}, 8'hB0 + WIDTH'(p - (STAGES - 1))});
    end

    // R6: clash between a load and its transfer keeps the loaded entry
    step(1'b1, 1'b0, 8'h5A);
    step(1'b1, 1'b1, 8'hFF);
    check_all("R6 clash mid-pair");
    step(1'b0, 1'b1, 8'h00);
    check_all("R6 after clash");
    check("R6 stage0 value", {{(PW-WIDTH){1'b0}}, par_o[0 +: WIDTH]}, {{(PW-WIDTH){1'b0}}, 8'h5A});

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule